// File: doc/BRIEF.md
# Up/Down Timer Counter Core

This block is the counting engine of a general-purpose timer. A 16-bit counter advances on a prescaler tick while the enable bit of a 32-bit control word is set. Edge-aligned counting runs upward or downward, and three centre-aligned modes bounce between zero and the reload value. Each wrap at a boundary is an overflow or underflow event. Software can write the control word, the reload value and one compare value through single-cycle write strobes. A software update strobe or an external update pulse restarts the count.

An update event follows from a wrap or from a restart request. It produces a one-clock pulse and moves a buffered reload value into the active reload register. It can also raise a sticky interrupt-request flag, depending on which sources the control word lets through. A one-pulse option clears the enable bit at the first update event. A sticky compare flag records each step that lands on the compare value. In centre-aligned modes that flag can be limited to one counting direction. The control word also picks a 1/2/4 divide ratio for a sampling-clock enable that neighbouring filter or dead-time logic uses.

Top module: `updown_tmr_core`

## Requirements
- R1: After reset every flag, the count, the enable status and the direction output are 0. While control bit 0 is 0, ticks leave the count unchanged.
- R2: While control bit 1 is 1, wraps and restart requests produce no update pulse and set no flag. Restart requests are then ignored: no reinitialisation and no reload transfer.
- R3: With control bit 2 at 0, a wrap, `sw_update` or `ext_update` sets `upd_flag`. With it at 1, only a wrap sets `upd_flag`, and restart requests still pulse `upd_pulse`.
- R4: In edge-aligned mode (bits 6:5 = 0) with bit 4 = 0, the count steps up and goes from the reload value to 0. With bit 4 = 1 it steps down and goes from 0 to the reload value. Each of these wraps is an update event.
- R5: With control bit 7 at 1, a reload write takes effect at the next update event. With it at 0, the write takes effect at once.
- R6: With control bit 3 at 1, an update event clears the enable bit (`en_q` goes to 0), so the count stops.
- R7: An effective restart request sets the count to 0 when counting up, or to the newest written reload value when counting down. It also moves that value into the active reload register.
- R8: `upd_pulse` is high for the clock after each update event. `upd_flag` and `cmp_flag` stay set until `clr_upd` / `clr_cmp` is pulsed.
- R9: In centre-aligned modes (bits 6:5 = 1, 2, 3) the count runs 0 up to the reload value and back down to 0, with a period of twice the reload value. The top turn is an overflow and the bottom turn an underflow. `dir_q` reports the phase (1 = down), and control bit 4 has no effect.
- R10: `cmp_flag` sets when a counting step yields the compare value. Mode 1 limits this to steps whose resulting direction is down, mode 2 to up, and modes 3 and 0 take both.
- R11: `dts_tick` is high on every clock for bits 9:8 = 0 or 3, on one clock in 2 for code 1, and on one clock in 4 for code 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctrl_wr | input | 1 | Control word write strobe |
| ctrl_wdata | input | 32 | Control word value |
| reload_wr | input | 1 | Reload value write strobe |
| reload_wdata | input | 16 | Reload value |
| cmp_wr | input | 1 | Compare value write strobe |
| cmp_wdata | input | 16 | Compare value |
| tick | input | 1 | Prescaler tick; one count step per tick |
| sw_update | input | 1 | Software update strobe |
| ext_update | input | 1 | External update request pulse |
| clr_upd | input | 1 | Clear update interrupt flag (write-one) |
| clr_cmp | input | 1 | Clear compare flag (write-one) |
| cnt_q | output | 16 | Current count |
| dir_q | output | 1 | Current direction, 1 = down |
| en_q | output | 1 | Counter enable status |
| upd_pulse | output | 1 | One-clock update event pulse |
| upd_flag | output | 1 | Sticky update interrupt request |
| cmp_flag | output | 1 | Sticky compare match flag |
| dts_tick | output | 1 | Divided sampling clock enable |

## Verification
On every cycle the assertions check several invariants: a disabled counter stays still, and suppressed updates never pulse. They also check that one-pulse mode drops the enable after an update event, that edge-aligned up-counting steps by exactly one below the top, and that both flags stay set until cleared. The alternation of the divided sampling enable at ratio 2 is checked the same way. Only the bench scenarios can show the rest. These are the exact wrap values in each mode, and the delay of a preloaded reload value until the next update. They also cover the direction gating of the compare flag across the three centre modes and the source filtering of the interrupt flag.

// File: rtl/tmr_pkg.sv
// Shared types for the up/down timer core.
// Assumes the control word bit layout given in the brief (bits 9:0 used).
package tmr_pkg;

    // Decoded control word, MSB first so a cast from bits 9:0 lines up
    typedef struct packed {
        logic [1:0] ckd;    // sampling clock divide code
        logic       arpe;   // reload buffering enable
        logic [1:0] cms;    // alignment mode
        logic       dir;    // edge-aligned direction, 1 = down
        logic       opm;    // stop at update event
        logic       urs;    // counter-only interrupt source
        logic       udis;   // update suppression
        logic       en;     // counter enable
    } tmr_cfg_t;

    localparam int CFG_W = $bits(tmr_cfg_t);

    typedef enum logic [1:0] {
        ALIGN_EDGE   = 2'd0,
        ALIGN_C_DOWN = 2'd1,
        ALIGN_C_UP   = 2'd2,
        ALIGN_C_BOTH = 2'd3
    } tmr_align_e;

    // Extract the used control fields from a written word
    function automatic tmr_cfg_t cfg_decode(input logic [31:0] word);
        return tmr_cfg_t'(word[CFG_W-1:0]);
    endfunction

endpackage

// File: rtl/tmr_cfg_reg.sv
// Control register of the timer core.
// Holds the decoded control word. A software write has priority over
// the one-pulse stop, which clears only the enable field.
module tmr_cfg_reg
    import tmr_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr,
    input  logic [31:0] wdata,
    input  logic        stop,
    output tmr_cfg_t    cfg_q
);

    // Load on write, drop enable on one-pulse stop
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (wr) begin
            cfg_q <= cfg_decode(wdata);
        end else if (stop) begin
            cfg_q.en <= 1'b0;
        end
    end

endmodule

// File: rtl/tmr_reload.sv
// Reload value storage with optional buffering.
// pre_q always holds the newest written value. act_q is the value the
// counter uses: written directly when buffering is off, otherwise copied
// from pre_q on each transfer request.
module tmr_reload #(
    parameter int          CNT_W      = 16,
    parameter logic [CNT_W-1:0] RESET_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [CNT_W-1:0] wdata,
    input  logic             buffered,
    input  logic             xfer,
    output logic [CNT_W-1:0] pre_q,
    output logic [CNT_W-1:0] act_q
);

    // Capture every software write into the buffer stage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q <= RESET_VAL;
        end else if (wr) begin
            pre_q <= wdata;
        end
    end

    // Update the active value: direct write or transfer at update event
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q <= RESET_VAL;
        end else if (wr && !buffered) begin
            act_q <= wdata;
        end else if (xfer) begin
            act_q <= pre_q;
        end
    end

endmodule

// File: rtl/tmr_count.sv
// Count register and direction state of the timer core.
// Computes the next count for edge and centre alignment, flags a wrap
// (overflow or underflow) and a compare hit gated by direction. A
// restart request overrides the step in the same cycle.
module tmr_count
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic             restart,
    input  tmr_align_e       align,
    input  logic             dir_cfg,
    input  logic [CNT_W-1:0] top,
    input  logic [CNT_W-1:0] restart_val,
    input  logic [CNT_W-1:0] cmp,
    output logic [CNT_W-1:0] cnt_q,
    output logic             dir_q,
    output logic             wrap,
    output logic             hit
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_nxt;
    logic             dir_nxt;
    logic             gate;

    // Next count, next direction and wrap detection
    always_comb begin
        cnt_nxt = cnt_q;
        dir_nxt = (align == ALIGN_EDGE) ? dir_cfg : dir_q;
        wrap    = 1'b0;
        if (restart) begin
            cnt_nxt = dir_nxt ? restart_val : '0;
        end else if (step) begin
            if (align == ALIGN_EDGE) begin
                if (!dir_nxt) begin
                    if (cnt_q >= top) begin
                        cnt_nxt = '0;
                        wrap    = 1'b1;
                    end else begin
                        cnt_nxt = cnt_q + ONE;
                    end
                end else begin
                    if (cnt_q == '0) begin
                        cnt_nxt = top;
                        wrap    = 1'b1;
                    end else begin
                        cnt_nxt = cnt_q - ONE;
                    end
                end
            end else begin
                if (!dir_q) begin
                    if (cnt_q >= top) begin
                        cnt_nxt = (top == '0) ? '0 : top - ONE;
                        dir_nxt = 1'b1;
                        wrap    = 1'b1;
                    end else begin
                        cnt_nxt = cnt_q + ONE;
                    end
                end else begin
                    if (cnt_q == '0) begin
                        cnt_nxt = (top == '0) ? '0 : ONE;
                        dir_nxt = 1'b0;
                        wrap    = 1'b1;
                    end else begin
                        cnt_nxt = cnt_q - ONE;
                    end
                end
            end
        end
    end

    // Direction filter for compare hits per alignment mode
    always_comb begin
        unique case (align)
            ALIGN_C_DOWN: gate = dir_nxt;
            ALIGN_C_UP:   gate = !dir_nxt;
            default:      gate = 1'b1;
        endcase
    end

    assign hit = step && !restart && (cnt_nxt == cmp) && gate;

    // Register count and direction
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            dir_q <= 1'b0;
        end else begin
            cnt_q <= cnt_nxt;
            dir_q <= dir_nxt;
        end
    end

endmodule

// File: rtl/tmr_div.sv
// Sampling clock enable divider.
// A free-running counter gives an enable every 1, 2 or 4 clocks.
// Code 3 behaves as code 0.
module tmr_div #(
    parameter int MAX_LOG = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] code,
    output logic       en_out
);

    logic [MAX_LOG-1:0] ph_q;

    // Free-running phase counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q <= '0;
        end else begin
            ph_q <= ph_q + MAX_LOG'(1);
        end
    end

    // Select the enable pattern for the divide code
    always_comb begin
        unique case (code)
            2'd1:    en_out = ph_q[0];
            2'd2:    en_out = &ph_q[1:0];
            default: en_out = 1'b1;
        endcase
    end

endmodule

// File: rtl/updown_tmr_core.sv
// Up/down timer counter core, top level.
// Joins the control register, reload storage, counter and divider, and
// forms the update event, the one-clock update pulse and the two sticky
// flags. All write strobes are single-cycle; inputs are synchronous.
module updown_tmr_core
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_wr,
    input  logic [31:0]      ctrl_wdata,
    input  logic             reload_wr,
    input  logic [CNT_W-1:0] reload_wdata,
    input  logic             cmp_wr,
    input  logic [CNT_W-1:0] cmp_wdata,
    input  logic             tick,
    input  logic             sw_update,
    input  logic             ext_update,
    input  logic             clr_upd,
    input  logic             clr_cmp,
    output logic [CNT_W-1:0] cnt_q,
    output logic             dir_q,
    output logic             en_q,
    output logic             upd_pulse,
    output logic             upd_flag,
    output logic             cmp_flag,
    output logic             dts_tick
);

    tmr_cfg_t         cfg_q;
    logic [CNT_W-1:0] arr_pre;
    logic [CNT_W-1:0] arr_act;
    logic [CNT_W-1:0] cmp_q;
    logic             step;
    logic             req;
    logic             restart;
    logic             wrap;
    logic             hit;
    logic             uev;
    logic             irq_set;

    assign step    = tick && cfg_q.en;
    assign req     = sw_update || ext_update;
    assign restart = req && !cfg_q.udis;
    assign uev     = !cfg_q.udis && (req || wrap);
    assign irq_set = uev && (wrap || !cfg_q.urs);
    assign en_q    = cfg_q.en;

    tmr_cfg_reg u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (ctrl_wr),
        .wdata (ctrl_wdata),
        .stop  (uev && cfg_q.opm),
        .cfg_q (cfg_q)
    );

    tmr_reload #(.CNT_W(CNT_W)) u_reload (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (reload_wr),
        .wdata    (reload_wdata),
        .buffered (cfg_q.arpe),
        .xfer     (uev),
        .pre_q    (arr_pre),
        .act_q    (arr_act)
    );

    tmr_count #(.CNT_W(CNT_W)) u_count (
        .clk         (clk),
        .rst_n       (rst_n),
        .step        (step),
        .restart     (restart),
        .align       (tmr_align_e'(cfg_q.cms)),
        .dir_cfg     (cfg_q.dir),
        .top         (arr_act),
        .restart_val (arr_pre),
        .cmp         (cmp_q),
        .cnt_q       (cnt_q),
        .dir_q       (dir_q),
        .wrap        (wrap),
        .hit         (hit)
    );

    tmr_div #(.MAX_LOG(2)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .code   (cfg_q.ckd),
        .en_out (dts_tick)
    );

    // Compare value register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_q <= '0;
        end else if (cmp_wr) begin
            cmp_q <= cmp_wdata;
        end
    end

    // Update pulse and sticky flags; a set beats a same-cycle clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upd_pulse <= 1'b0;
            upd_flag  <= 1'b0;
            cmp_flag  <= 1'b0;
        end else begin
            upd_pulse <= uev;
            upd_flag  <= irq_set || (upd_flag && !clr_upd);
            cmp_flag  <= hit || (cmp_flag && !clr_cmp);
        end
    end

endmodule

// File: rtl/tmr_core_chk.sv
// Assertion checker for the up/down timer core, bound to the top.
// Observes ports and internal decode signals; drives nothing.
module tmr_core_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en_q,
    input logic             req,
    input logic [CNT_W-1:0] cnt_q,
    input logic [CNT_W-1:0] arr_act,
    input logic             upd_pulse,
    input logic             upd_flag,
    input logic             clr_upd,
    input logic             cmp_flag,
    input logic             clr_cmp,
    input logic             udis,
    input logic             opm,
    input logic             ctrl_wr,
    input logic             uev,
    input logic             step,
    input logic             edge_up,
    input logic [1:0]       ckd,
    input logic             dts_tick
);

    // R1
    hold_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_q && !req) |=> $stable(cnt_q));

    // R2
    no_update_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        udis |=> !upd_pulse);

    // R6
    one_pulse_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (uev && opm && !ctrl_wr) |=> !en_q);

    // R4
    up_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_up && step && !req && (cnt_q < arr_act)) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));

    // R8
    upd_flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_flag && !clr_upd) |=> upd_flag);

    // R8
    cmp_flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_flag && !clr_cmp) |=> cmp_flag);

    // R11
    half_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dts_tick && ckd == 2'd1 && !ctrl_wr) |=> !dts_tick);

endmodule

bind updown_tmr_core tmr_core_chk #(.CNT_W(CNT_W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_q      (en_q),
    .req       (req),
    .cnt_q     (cnt_q),
    .arr_act   (arr_act),
    .upd_pulse (upd_pulse),
    .upd_flag  (upd_flag),
    .clr_upd   (clr_upd),
    .cmp_flag  (cmp_flag),
    .clr_cmp   (clr_cmp),
    .udis      (cfg_q.udis),
    .opm       (cfg_q.opm),
    .ctrl_wr   (ctrl_wr),
    .uev       (uev),
    .step      (step),
    .edge_up   ((cfg_q.cms == 2'd0) && !cfg_q.dir),
    .ckd       (cfg_q.ckd),
    .dts_tick  (dts_tick)
);

// File: tb/test_updown_tmr_core.sv
// Scoreboard bench for the up/down timer core. Driver tasks push expected
// items; a monitor pops them and compares against the design outputs.
module test_updown_tmr_core;

    localparam int K_CNT = 0, K_PUL = 1, K_UFL = 2, K_CFL = 3, K_DIR = 4, K_EN = 5, K_DTS = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctrl_wr = 1'b0;
    logic [31:0] ctrl_wdata = '0;
    logic        reload_wr = 1'b0;
    logic [15:0] reload_wdata = '0;
    logic        cmp_wr = 1'b0;
    logic [15:0] cmp_wdata = '0;
    logic        tick = 1'b0;
    logic        sw_update = 1'b0;
    logic        ext_update = 1'b0;
    logic        clr_upd = 1'b0;
    logic        clr_cmp = 1'b0;
    logic [15:0] cnt_q;
    logic        dir_q, en_q, upd_pulse, upd_flag, cmp_flag, dts_tick;

    int checks = 0;
    int errors = 0;
    int dts_seen = 0;
    bit done = 1'b0;

    typedef struct {
        int    kind;
        int    exp;
        string tag;
    } item_t;

    item_t sb_q[$];
    event  chk_ev;

    always #10 clk = ~clk;

    updown_tmr_core i_updown_tmr_core (
        .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
        .reload_wr(reload_wr), .reload_wdata(reload_wdata), .cmp_wr(cmp_wr),
        .cmp_wdata(cmp_wdata), .tick(tick), .sw_update(sw_update),
        .ext_update(ext_update), .clr_upd(clr_upd), .clr_cmp(clr_cmp),
        .cnt_q(cnt_q), .dir_q(dir_q), .en_q(en_q), .upd_pulse(upd_pulse),
        .upd_flag(upd_flag), .cmp_flag(cmp_flag), .dts_tick(dts_tick)
    );

    // Monitor: pop expected items and compare with the outputs
    initial begin
        forever begin
            @(chk_ev);
            while (sb_q.size() > 0) begin
                item_t it;
                int act;
                it = sb_q.pop_front();
                case (it.kind)
                    K_CNT:   act = int'(cnt_q);
                    K_PUL:   act = int'(upd_pulse);
                    K_UFL:   act = int'(upd_flag);
                    K_CFL:   act = int'(cmp_flag);
                    K_DIR:   act = int'(dir_q);
                    K_EN:    act = int'(en_q);
                    default: act = dts_seen;
                endcase
                checks++;
                if (act != it.exp) begin
                    errors++;
                    $display("FAIL %s kind=%0d actual=%0d expected=%0d", it.tag, it.kind, act, it.exp);
                end
            end
        end
    end

    task automatic expect_v(input int kind, input int val, input string tag);
        item_t it;
        it.kind = kind; it.exp = val; it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic flush();
        -> chk_ev;
        #1;
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic wr_ctrl(input logic [31:0] v);
        ctrl_wdata = v; ctrl_wr = 1'b1; cyc(); ctrl_wr = 1'b0;
    endtask

    task automatic wr_arr(input logic [15:0] v);
        reload_wdata = v; reload_wr = 1'b1; cyc(); reload_wr = 1'b0;
    endtask

    task automatic wr_cmp(input logic [15:0] v);
        cmp_wdata = v; cmp_wr = 1'b1; cyc(); cmp_wr = 1'b0;
    endtask

    task automatic do_tick();
        tick = 1'b1; cyc(); tick = 1'b0;
    endtask

    task automatic do_sw();
        sw_update = 1'b1; cyc(); sw_update = 1'b0;
    endtask

    task automatic do_ext();
        ext_update = 1'b1; cyc(); ext_update = 1'b0;
    endtask

    task automatic do_clr();
        clr_upd = 1'b1; clr_cmp = 1'b1; cyc(); clr_upd = 1'b0; clr_cmp = 1'b0;
    endtask

    task automatic tick_cnt(input int val, input string tag);
        do_tick();
        expect_v(K_CNT, val, tag);
        flush();
    endtask

    task automatic dts_count(input logic [31:0] v, input int exp);
        int n;
        wr_ctrl(v);
        n = 0;
        for (int i = 0; i < 8; i++) begin
            if (dts_tick) n++;
            cyc();
        end
        dts_seen = n;
        expect_v(K_DTS, exp, "R11");
        flush();
    endtask

    // Watchdog: a hung run is a failure and still reports
    initial begin
        #(20 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog all-reqs actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // Driver: scenarios
    initial begin
        repeat (3) cyc();
        rst_n = 1'b1;
        cyc();
        // R1 reset state
        expect_v(K_CNT, 0, "R1"); expect_v(K_PUL, 0, "R1"); expect_v(K_UFL, 0, "R1");
        expect_v(K_CFL, 0, "R1"); expect_v(K_EN, 0, "R1"); expect_v(K_DIR, 0, "R1");
        flush();
        tick_cnt(0, "R1");

        // R4 edge up with top 3, compare 0
        wr_arr(16'd3);
        wr_ctrl(32'h01);
        expect_v(K_EN, 1, "R1"); flush();
        tick_cnt(1, "R4"); tick_cnt(2, "R4"); tick_cnt(3, "R4");
        expect_v(K_PUL, 0, "R4"); flush();
        tick_cnt(0, "R4");
        expect_v(K_PUL, 1, "R4"); expect_v(K_UFL, 1, "R8"); expect_v(K_CFL, 1, "R10"); flush();
        cyc();
        expect_v(K_PUL, 0, "R8"); expect_v(K_UFL, 1, "R8"); flush();
        do_clr();
        expect_v(K_UFL, 0, "R8"); expect_v(K_CFL, 0, "R8"); flush();

        // R4 edge down
        wr_ctrl(32'h11);
        tick_cnt(3, "R4");
        expect_v(K_PUL, 1, "R4"); expect_v(K_DIR, 1, "R4"); flush();
        tick_cnt(2, "R4"); tick_cnt(1, "R4"); tick_cnt(0, "R4");
        expect_v(K_PUL, 0, "R4"); flush();
        do_clr();

        // R2 suppression of update events
        wr_ctrl(32'h13);
        tick_cnt(3, "R2");
        expect_v(K_PUL, 0, "R2"); expect_v(K_UFL, 0, "R2"); flush();
        do_sw();
        expect_v(K_CNT, 3, "R2"); expect_v(K_PUL, 0, "R2"); flush();

        // R3 counter-only interrupt source
        wr_ctrl(32'h05);
        do_clr();
        do_sw();
        expect_v(K_CNT, 0, "R7"); expect_v(K_PUL, 1, "R3"); expect_v(K_UFL, 0, "R3"); flush();
        do_ext();
        expect_v(K_PUL, 1, "R3"); expect_v(K_UFL, 0, "R3"); flush();
        tick_cnt(1, "R3"); tick_cnt(2, "R3"); tick_cnt(3, "R3"); tick_cnt(0, "R3");
        expect_v(K_UFL, 1, "R3"); flush();
        do_clr();

        // R3 any source, R7 restart value
        wr_ctrl(32'h01);
        tick_cnt(1, "R7"); tick_cnt(2, "R7");
        do_sw();
        expect_v(K_CNT, 0, "R7"); expect_v(K_PUL, 1, "R3"); expect_v(K_UFL, 1, "R3"); flush();
        do_clr();
        do_ext();
        expect_v(K_UFL, 1, "R3"); flush();
        do_clr();
        wr_ctrl(32'h10);
        do_sw();
        expect_v(K_CNT, 3, "R7"); expect_v(K_EN, 0, "R7"); flush();

        // R5 buffered reload
        wr_ctrl(32'h00);
        do_sw();
        wr_ctrl(32'h81);
        wr_arr(16'd5);
        tick_cnt(1, "R5"); tick_cnt(2, "R5"); tick_cnt(3, "R5"); tick_cnt(0, "R5");
        expect_v(K_PUL, 1, "R5"); flush();
        tick_cnt(1, "R5"); tick_cnt(2, "R5"); tick_cnt(3, "R5"); tick_cnt(4, "R5");
        tick_cnt(5, "R5"); tick_cnt(0, "R5");
        // R7 restart transfers the buffered value
        wr_arr(16'd2);
        do_sw();
        expect_v(K_CNT, 0, "R7"); flush();
        tick_cnt(1, "R7"); tick_cnt(2, "R7"); tick_cnt(0, "R7");
        expect_v(K_PUL, 1, "R7"); flush();
        // R5 direct reload
        wr_ctrl(32'h01);
        wr_arr(16'd1);
        tick_cnt(1, "R5"); tick_cnt(0, "R5");
        expect_v(K_PUL, 1, "R5"); flush();
        do_clr();

        // R6 one-pulse stop
        wr_arr(16'd2);
        wr_ctrl(32'h09);
        tick_cnt(1, "R6"); tick_cnt(2, "R6"); tick_cnt(0, "R6");
        expect_v(K_EN, 0, "R6"); flush();
        tick_cnt(0, "R6"); tick_cnt(0, "R6");
        expect_v(K_PUL, 0, "R6"); flush();

        // R9 R10 centre mode 1 (compare on down steps)
        wr_ctrl(32'h00);
        do_sw();
        wr_arr(16'd3);
        wr_cmp(16'd2);
        do_clr();
        wr_ctrl(32'h21);
        tick_cnt(1, "R9"); tick_cnt(2, "R9");
        expect_v(K_CFL, 0, "R10"); expect_v(K_DIR, 0, "R9"); flush();
        tick_cnt(3, "R9"); tick_cnt(2, "R9");
        expect_v(K_CFL, 1, "R10"); expect_v(K_DIR, 1, "R9"); expect_v(K_PUL, 1, "R9"); flush();
        tick_cnt(1, "R9"); tick_cnt(0, "R9");
        expect_v(K_PUL, 0, "R9"); flush();
        tick_cnt(1, "R9");
        expect_v(K_PUL, 1, "R9"); expect_v(K_DIR, 0, "R9"); flush();

        // R10 centre mode 2 (compare on up steps)
        wr_ctrl(32'h00);
        do_sw();
        do_clr();
        wr_ctrl(32'h41);
        tick_cnt(1, "R10"); tick_cnt(2, "R10");
        expect_v(K_CFL, 1, "R10"); flush();
        do_clr();
        tick_cnt(3, "R10"); tick_cnt(2, "R10");
        expect_v(K_CFL, 0, "R10"); expect_v(K_DIR, 1, "R10"); flush();

        // R9 direction bit ignored, R10 mode 3 both directions
        wr_ctrl(32'h00);
        do_sw();
        do_clr();
        wr_ctrl(32'h71);
        cyc();
        expect_v(K_DIR, 0, "R9"); flush();
        tick_cnt(1, "R9"); tick_cnt(2, "R10");
        expect_v(K_CFL, 1, "R10"); flush();
        do_clr();
        tick_cnt(3, "R10"); tick_cnt(2, "R10");
        expect_v(K_CFL, 1, "R10"); flush();

        // R11 sampling clock divide codes
        dts_count(32'h000, 8);
        dts_count(32'h100, 4);
        dts_count(32'h200, 2);
        dts_count(32'h300, 8);

        cyc();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule